// File: doc/BRIEF.md
# Reverse-Direction Single-Word Mailbox

This block is a one-word register that carries a short control or status word in the direction opposite to the main FIFO flow of a two-port buffer. Each port has an active-low bypass select and an active-low data strobe. The FIFO direction is latched while reset is held, and it decides the roles of the two ports. The port that reads the FIFO writes the mailbox. The port that writes the FIFO reads the mailbox. An active-low flag, `bdaN`, tells the reading side that a word is waiting.

The writing port holds its bypass select low with its strobe high and presents the word on its input bus. The register takes the word when the select returns high. The reading port holds its bypass select low with its strobe high, and the word appears on its output bus with that port's output enable asserted. Neither side is gated by the flag. A write always overwrites the register, and a read may happen whether or not a word is pending. Any cycle of a bypass phase in which the same port's strobe is low voids that whole access. All inputs are treated as synchronous to `clk`.

Top module: `bypass_mailbox`

## Requirements
- R1: While `rstN` is low, the register clears to zero, `bdaN` is 1 and both output enables are 0. A read made right after reset returns 0.
- R2: The value of `dirSel` sampled during reset is the direction; 1 means FIFO A-to-B, so port B writes the mailbox and port A reads it, and 0 is the reverse. Changes of `dirSel` after reset have no effect.
- R3: A write is committed at the first clock edge that samples the writer's bypass select high after one or more low samples. The stored word is the writer's input bus as sampled at the last low edge, and `bdaN` goes to 0 at the same edge.
- R4: In any cycle where the reader's bypass select is low and its strobe is high (outside reset), that port's output enable is 1 in the same cycle and its output bus carries the stored word. Otherwise the output bus is 0.
- R5: `bdaN` returns to 1 at the first edge that samples the reader's select high after a valid read phase.
- R6: A write overwrites the stored word even while `bdaN` is 0. A read is permitted while `bdaN` is 1; it returns the current word and leaves `bdaN` at 1.
- R7: If the same port's strobe is sampled low on any edge of a bypass-low phase, the phase is void. A void write leaves the word and `bdaN` unchanged. A void read leaves `bdaN` unchanged, and output enable is 0 in the cycles with the strobe low.
- R8: When a write commit and a read commit fall on the same edge, the new word is stored and `bdaN` ends at 0.
- R9: The writer port's output enable is never asserted, and the two output enables are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; direction is sampled while low |
| dirSel | input | 1 | FIFO direction request: 1 = A-to-B, 0 = B-to-A |
| bypAN | input | 1 | Port A bypass select, active low |
| stbAN | input | 1 | Port A data strobe, active low |
| bypBN | input | 1 | Port B bypass select, active low |
| stbBN | input | 1 | Port B data strobe, active low |
| portAIn | input | WIDTH | Port A input word |
| portBIn | input | WIDTH | Port B input word |
| portAOut | output | WIDTH | Port A mailbox output word |
| portAOe | output | 1 | Port A output enable |
| portBOut | output | WIDTH | Port B mailbox output word |
| portBOe | output | 1 | Port B output enable |
| bdaN | output | 1 | Mailbox data available, active low |

## Verification
The flag-edge properties assume that the direction does not move after reset. They also assume that a bypass select is held for at least one sampled edge before it is released, so that every flag transition can be traced back to a select low-to-high pair two samples deep. The stimulus drives all inputs on the falling clock edge. It keeps each select low for at least two edges and changes direction only inside a reset pulse. It also exercises one deliberate case where both ports finish on the same edge, with the reader running concurrently.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Strobes handed from control to datapath each cycle.
  typedef struct packed {
    logic clear;      // reset: zero the storage
    logic srcIsB;     // writer bus select: 1 = port B
    logic stageLoad;  // valid writer low cycle: stage the bus
    logic commitWr;   // writer released a valid phase: store staged word
    logic oeA;        // drive mailbox onto port A
    logic oeB;        // drive mailbox onto port B
  } mboxCtl_t;

  localparam int PORT_A = 0;
  localparam int PORT_B = 1;
endpackage

// File: rtl/mbox_phase_track.sv
module mbox_phase_track (
  input  logic clk,
  input  logic rstN,
  input  logic bypN,
  input  logic stbN,
  output logic phaseOk,
  output logic commit
);
  logic lowQ;  // select was low at the previous edge
  logic okQ;   // every low sample so far had strobe high

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowQ <= 1'b0;
      okQ  <= 1'b0;
    end else if (!bypN) begin
      lowQ <= 1'b1;
      okQ  <= (lowQ ? okQ : 1'b1) & stbN;
    end else begin
      lowQ <= 1'b0;
      okQ  <= 1'b0;
    end
  end

  assign phaseOk = rstN & ~bypN & stbN;
  assign commit  = rstN & bypN & lowQ & okQ;
endmodule

// File: rtl/mbox_ctl.sv
module mbox_ctl
  import mbox_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     dirSel,
  input  logic     bypAN,
  input  logic     stbAN,
  input  logic     bypBN,
  input  logic     stbBN,
  output mboxCtl_t ctl,
  output logic     dirAtoBQ,
  output logic     bdaN
);
  localparam int NPORT = 2;

  logic [NPORT-1:0] bypVec;
  logic [NPORT-1:0] stbVec;
  logic [NPORT-1:0] phaseOk;
  logic [NPORT-1:0] commit;
  logic             wrCommit;
  logic             rdCommit;

  assign bypVec = {bypBN, bypAN};
  assign stbVec = {stbBN, stbAN};

  always_ff @(posedge clk) begin
    if (!rstN) dirAtoBQ <= dirSel;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_track
    mbox_phase_track u_track (
      .clk    (clk),
      .rstN   (rstN),
      .bypN   (bypVec[p]),
      .stbN   (stbVec[p]),
      .phaseOk(phaseOk[p]),
      .commit (commit[p])
    );
  end

  // FIFO A-to-B: B writes the mailbox, A reads it.
  assign wrCommit = dirAtoBQ ? commit[PORT_B] : commit[PORT_A];
  assign rdCommit = dirAtoBQ ? commit[PORT_A] : commit[PORT_B];

  always_ff @(posedge clk) begin
    if (!rstN)         bdaN <= 1'b1;
    else if (wrCommit) bdaN <= 1'b0;
    else if (rdCommit) bdaN <= 1'b1;
  end

  always_comb begin
    ctl.clear     = ~rstN;
    ctl.srcIsB    = dirAtoBQ;
    ctl.stageLoad = dirAtoBQ ? phaseOk[PORT_B] : phaseOk[PORT_A];
    ctl.commitWr  = wrCommit;
    ctl.oeA       = phaseOk[PORT_A] & dirAtoBQ;
    ctl.oeB       = phaseOk[PORT_B] & ~dirAtoBQ;
  end
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  mboxCtl_t         ctl,
  input  logic [WIDTH-1:0] portAIn,
  input  logic [WIDTH-1:0] portBIn,
  output logic [WIDTH-1:0] portAOut,
  output logic             portAOe,
  output logic [WIDTH-1:0] portBOut,
  output logic             portBOe
);
  localparam int NPORT = 2;

  logic [WIDTH-1:0] stageQ;
  logic [WIDTH-1:0] wordQ;
  logic [WIDTH-1:0] outWord [NPORT];
  logic [NPORT-1:0] oeVec;

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      stageQ <= '0;
      wordQ  <= '0;
    end else begin
      if (ctl.stageLoad) stageQ <= ctl.srcIsB ? portBIn : portAIn;
      if (ctl.commitWr)  wordQ  <= stageQ;
    end
  end

  assign oeVec = {ctl.oeB, ctl.oeA};

  for (genvar p = 0; p < NPORT; p++) begin : g_out
    assign outWord[p] = oeVec[p] ? wordQ : '0;
  end

  assign portAOut = outWord[PORT_A];
  assign portBOut = outWord[PORT_B];
  assign portAOe  = oeVec[PORT_A];
  assign portBOe  = oeVec[PORT_B];
endmodule

// File: rtl/bypass_mailbox.sv
module bypass_mailbox
  import mbox_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirSel,
  input  logic             bypAN,
  input  logic             stbAN,
  input  logic             bypBN,
  input  logic             stbBN,
  input  logic [WIDTH-1:0] portAIn,
  input  logic [WIDTH-1:0] portBIn,
  output logic [WIDTH-1:0] portAOut,
  output logic             portAOe,
  output logic [WIDTH-1:0] portBOut,
  output logic             portBOe,
  output logic             bdaN
);
  mboxCtl_t ctl;
  logic     dirAtoBQ;

  mbox_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .dirSel  (dirSel),
    .bypAN   (bypAN),
    .stbAN   (stbAN),
    .bypBN   (bypBN),
    .stbBN   (stbBN),
    .ctl     (ctl),
    .dirAtoBQ(dirAtoBQ),
    .bdaN    (bdaN)
  );

  mbox_dp #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .ctl     (ctl),
    .portAIn (portAIn),
    .portBIn (portBIn),
    .portAOut(portAOut),
    .portAOe (portAOe),
    .portBOut(portBOut),
    .portBOe (portBOe)
  );
endmodule

// File: rtl/mbox_checks.sv
module mbox_checks (
  input logic clk,
  input logic rstN,
  input logic bypAN,
  input logic stbAN,
  input logic bypBN,
  input logic stbBN,
  input logic portAOe,
  input logic portBOe,
  input logic bdaN,
  input logic dirAtoBQ
);
  logic wrBypN;
  logic rdBypN;
  assign wrBypN = dirAtoBQ ? bypBN : bypAN;
  assign rdBypN = dirAtoBQ ? bypAN : bypBN;

  // R1: reset leaves the flag in the no-data state
  a_r1_reset_flag: assert property (@(posedge clk) !rstN |=> bdaN);

  // R9: never both ports driving
  a_r9_oe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(portAOe && portBOe));

  // R9: writer side stays quiet
  a_r9_writer_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (dirAtoBQ ? !portBOe : !portAOe));

  // R7: enable only with select low and strobe high on that port
  a_r7_oe_a_qualified: assert property (@(posedge clk) disable iff (!rstN)
    portAOe |-> (!bypAN && stbAN));
  a_r7_oe_b_qualified: assert property (@(posedge clk) disable iff (!rstN)
    portBOe |-> (!bypBN && stbBN));

  // R3: flag falls only after a writer low-to-high select pair
  a_r3_flag_fall_src: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bdaN) |-> ($past(wrBypN) && !$past(wrBypN, 2)));

  // R5: flag rises only after a reader low-to-high select pair
  a_r5_flag_rise_src: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bdaN) |-> ($past(rdBypN) && !$past(rdBypN, 2)));
endmodule

bind bypass_mailbox mbox_checks u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .bypAN   (bypAN),
  .stbAN   (stbAN),
  .bypBN   (bypBN),
  .stbBN   (stbBN),
  .portAOe (portAOe),
  .portBOe (portBOe),
  .bdaN    (bdaN),
  .dirAtoBQ(dirAtoBQ)
);

// File: tb/bypass_mailbox_tb.sv
module bypass_mailbox_tb;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         dirSel = 1'b1;
  logic         bypAN = 1'b1, stbAN = 1'b1, bypBN = 1'b1, stbBN = 1'b1;
  logic [W-1:0] portAIn = '0, portBIn = '0;
  logic [W-1:0] portAOut, portBOut;
  logic         portAOe, portBOe, bdaN;

  int nChk = 0;
  int nBad = 0;
  logic         curDir;
  logic [W-1:0] expWord;
  logic         expBda;

  always #10 clk = ~clk;  // 50 MHz

  bypass_mailbox #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .dirSel(dirSel),
    .bypAN(bypAN), .stbAN(stbAN), .bypBN(bypBN), .stbBN(stbBN),
    .portAIn(portAIn), .portBIn(portBIn),
    .portAOut(portAOut), .portAOe(portAOe),
    .portBOut(portBOut), .portBOe(portBOe), .bdaN(bdaN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // p: 0 = port A, 1 = port B
  task automatic setPort(input int p, input logic byp, input logic stb, input logic [W-1:0] d);
    if (p == 0) begin bypAN = byp; stbAN = stb; portAIn = d; end
    else        begin bypBN = byp; stbBN = stb; portBIn = d; end
  endtask

  function automatic int wrPort();
    return curDir ? 1 : 0;
  endfunction

  task automatic doReset(input logic d);
    @(negedge clk);
    rstN = 1'b0; dirSel = d;
    setPort(0, 1'b1, 1'b1, '0);
    setPort(1, 1'b1, 1'b1, '0);
    repeat (2) @(negedge clk);
    chk("R1 flag in reset", bdaN, 1'b1);
    chk("R1 oe in reset", {portAOe, portBOe}, 2'b00);
    rstN = 1'b1;
    dirSel = ~d;  // R2: must be ignored from now on
    curDir = d; expWord = '0; expBda = 1'b1;
  endtask

  task automatic mWrite(input logic [W-1:0] w, input bit spoil);
    int wp = wrPort();
    setPort(wp, 1'b0, 1'b1, w);
    @(negedge clk);
    if (spoil) setPort(wp, 1'b0, 1'b0, w);
    @(negedge clk);
    setPort(wp, 1'b1, 1'b1, ~w);
    @(negedge clk);
    if (!spoil) begin expWord = w; expBda = 1'b0; end
    chk(spoil ? "R7 void write flag" : "R3 write flag", bdaN, expBda);
  endtask

  task automatic mRead(input bit spoil);
    int rp = 1 - wrPort();
    setPort(rp, 1'b0, 1'b1, 9'h1C3);
    #2;
    chk("R4 reader oe", rp == 0 ? portAOe : portBOe, 1'b1);
    chk("R4 reader word", rp == 0 ? portAOut : portBOut, expWord);
    chk("R9 writer oe", rp == 0 ? portBOe : portAOe, 1'b0);
    @(negedge clk);
    if (spoil) begin
      setPort(rp, 1'b0, 1'b0, '0);
      #2 chk("R7 oe off with strobe low", rp == 0 ? portAOe : portBOe, 1'b0);
    end
    @(negedge clk);
    setPort(rp, 1'b1, 1'b1, '0);
    #2 chk("R4 idle output zero", rp == 0 ? portAOut : portBOut, '0);
    @(negedge clk);
    if (!spoil) expBda = 1'b1;
    chk(spoil ? "R7 void read flag" : "R5 read flag", bdaN, expBda);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin : stim
    for (int d = 1; d >= 0; d--) begin
      doReset(d[0]);
      mRead(0);  // R1/R6: empty read returns zero, flag stays high
      for (int i = 0; i < 12; i++) begin
        logic [W-1:0] w;
        w = (i == 0) ? 9'h1FF : (i == 1) ? 9'h000 : W'((i * 151 + d * 77) % 512);
        mWrite(w, 0);
        if (i % 3 == 0) mWrite(w ^ 9'h155, 0);  // R6 overwrite while pending
        mRead(0);
        if (i % 4 == 1) mRead(0);               // R6 read while empty
      end
      // R7 void accesses
      mWrite(9'h0F0, 1);
      mRead(1);
      mWrite(9'h123, 0);
      mRead(1);
      mRead(0);
      // R8 concurrent commit on the same edge
      mWrite(9'h0AA, 0);
      setPort(wrPort(), 1'b0, 1'b1, 9'h155);
      setPort(1 - wrPort(), 1'b0, 1'b1, '0);
      #2 chk("R8 concurrent read sees old", wrPort() == 1 ? portAOut : portBOut, 9'h0AA);
      @(negedge clk); @(negedge clk);
      setPort(0, 1'b1, 1'b1, '0);
      setPort(1, 1'b1, 1'b1, '0);
      @(negedge clk);
      expWord = 9'h155; expBda = 1'b0;
      chk("R8 concurrent flag", bdaN, 1'b0);
      mRead(0);
      // R1 mid-run reset clears the word
      mWrite(9'h1AB, 0);
      doReset(d[0]);
      mRead(0);
      chk("R2 direction held", u_dut.portAOe | u_dut.portBOe, 1'b0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule